// File: doc/BRIEF.md
# Long-Word Cache Entry Fill Sequencer

This block gathers one 32-bit cache entry from a read port that may be 8, 16 or 32 bits wide. A cacheable read miss hands it a byte address. The block then runs one or more bus read cycles. The first cycle asks for the requested byte. Later cycles wrap back to fill the rest of the same aligned long word. On each cycle the port answers with a size acknowledge. That answer decides which byte lanes are taken and which address comes next.

The entry has a single valid bit. It can therefore only be marked valid once all four bytes are held. When the last byte arrives, the block writes the assembled long word and sets the valid bit. A bus error, a cache-inhibit answer or a change of reported port width ends the fill and writes the entry as invalid. The requested byte goes to the core as soon as the cycle that carries it completes, without waiting for the rest of the fill.

The request side is a valid/ready pair. `req_ready` is high exactly when no fill is running. A request held while `req_ready` is low is not taken, and the requester must keep it until it is accepted. The operand result and the entry write are single-cycle strobes with no back-pressure: the core and the cache array must take them in the cycle they appear.

Top module: `lw_fill_seq`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `bus_req` is high and `bus_addr` equals the requested byte address. A request offered while a fill runs is not taken, and no further fill starts after the running one ends.
- R2: `bus_ack` is encoded 00 = wait, 01 = 8-bit port, 10 = 16-bit port, 11 = 32-bit port. A cycle ends on an edge where `bus_ack` is not 00 or `bus_berr` is high. While a cycle waits, `bus_addr` holds and nothing is reported.
- R3: With 8-bit answers, the cycles read the requested offset first. Each later cycle then reads the lowest byte offset not yet held (offset 3 gives 3,0,1,2; offset 1 gives 1,0,2,3). The fill takes four cycles.
- R4: With 16-bit answers, the first cycle takes the aligned word holding the requested byte. The second cycle is addressed at the lowest offset not yet held (0 or 2). The fill takes two cycles.
- R5: A 32-bit answer fills the entry in a single cycle.
- R6: Lane steering. An 8-bit port delivers on `bus_data[31:24]`. A 16-bit port delivers its lower-offset byte on `[31:24]` and the next byte on `[23:16]`. A 32-bit port puts offset 0 on `[31:24]` through offset 3 on `[7:0]`. The entry uses the same order: the byte at offset k sits at `cw_data[31-8k -: 8]`. Unused lanes are ignored.
- R7: One cycle after the edge that ends the first bus cycle without a bus error, `op_valid` pulses once with `op_data` equal to the requested byte. This also happens when cache-inhibit is set on that cycle. `op_valid` stays low on every other cycle of the fill.
- R8: One cycle after the edge that completes the last missing byte, `cw_en` and `cw_valid` pulse high. `cw_data` then holds the full long word and `cw_line` holds the requested address without its two low bits.
- R9: A cycle that ends with `bus_berr` or `bus_ci` high aborts the fill. One cycle later `cw_en` pulses with `cw_valid` low, and no further bus cycle is issued. If this happens on the first cycle with `bus_berr`, `op_err` pulses instead of `op_valid`.
- R10: If a later cycle reports a width different from the first cycle, the fill aborts in the same way as R9. The operand already delivered stands.
- R11: `busy` is low out of reset. It is high from the cycle after acceptance until the edge that ends the fill, and low in the cycle where `cw_en` pulses. `req_ready` is the inverse of `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fill request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Byte address of the missed operand |
| busy | output | 1 | Fill in progress |
| bus_req | output | 1 | Bus read cycle requested |
| bus_addr | output | ADDR_W | Byte address of the current bus cycle |
| bus_ack | input | 2 | Port-size acknowledge (00 wait, 01 8-bit, 10 16-bit, 11 32-bit) |
| bus_berr | input | 1 | Bus error, ends the cycle |
| bus_ci | input | 1 | Cache inhibit for the ending cycle |
| bus_data | input | 32 | Read data, upper lanes used by narrow ports |
| op_valid | output | 1 | Requested byte delivered |
| op_data | output | 8 | Requested byte |
| op_err | output | 1 | Requested byte failed with bus error |
| cw_en | output | 1 | Cache entry write strobe |
| cw_valid | output | 1 | Valid bit value written with the entry |
| cw_line | output | ADDR_W-2 | Long-word address of the entry |
| cw_data | output | 32 | Assembled long word |

## Verification
The bus address of the first cycle is due one cycle after the accepting edge. Every result that depends on a bus answer (operand strobe, error strobe, entry write, next address, fall of `busy`) is due one cycle after the edge that samples that answer. The bench drives each answer at a falling edge and reads the outputs at the falling edge that follows the next rising edge, so every check lands in exactly the cycle the requirement names. During wait states it re-reads the address and the strobes on each falling edge. After each fill ends, it also checks one extra idle cycle.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  localparam int LW_BYTES = 4;
  localparam int OFF_W = $clog2(LW_BYTES);

  typedef enum logic [1:0] {
    ACK_WAIT = 2'b00,
    ACK_B8   = 2'b01,
    ACK_B16  = 2'b10,
    ACK_B32  = 2'b11
  } ack_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } st_e;
endpackage

// File: rtl/lwf_lane_steer.sv
module lwf_lane_steer
  import lwf_pkg::*;
(
  input  ack_e        width,
  input  logic [31:0] bus_data,
  output logic [31:0] steered
);
  // Byte k of the entry lives at [8*(3-k) +: 8]; choose its source lane.
  for (genvar k = 0; k < LW_BYTES; k++) begin : g_lane
    localparam int POS   = 8 * (LW_BYTES - 1 - k);
    localparam int POS16 = 8 * (LW_BYTES - 1 - (k % 2));
    always_comb begin
      unique case (width)
        ACK_B32: steered[POS +: 8] = bus_data[POS +: 8];
        ACK_B16: steered[POS +: 8] = bus_data[POS16 +: 8];
        default: steered[POS +: 8] = bus_data[31:24];
      endcase
    end
  end
endmodule

// File: rtl/lwf_offset_plan.sv
module lwf_offset_plan
  import lwf_pkg::*;
(
  input  ack_e                width,
  input  logic [OFF_W-1:0]    off,
  input  logic [LW_BYTES-1:0] have,
  output logic [LW_BYTES-1:0] gain,
  output logic [LW_BYTES-1:0] have_nxt,
  output logic [OFF_W-1:0]    next_off,
  output logic                full
);
  always_comb begin
    unique case (width)
      ACK_B8:  gain = LW_BYTES'(1) << off;
      ACK_B16: gain = off[1] ? 4'b1100 : 4'b0011;
      ACK_B32: gain = '1;
      default: gain = '0;
    endcase
  end

  assign have_nxt = have | gain;
  assign full     = &have_nxt;

  // Lowest byte offset still missing after this cycle.
  always_comb begin
    next_off = '0;
    for (int k = LW_BYTES - 1; k >= 0; k--) begin
      if (!have_nxt[k]) next_off = OFF_W'(k);
    end
  end
endmodule

// File: rtl/lwf_entry_asm.sv
module lwf_entry_asm
  import lwf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                load,
  input  logic [LW_BYTES-1:0] gain,
  input  logic [31:0]         din,
  output logic [31:0]         entry_q,
  output logic [LW_BYTES-1:0] have_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    have_q <= '0;
    else if (clr)  have_q <= '0;
    else if (load) have_q <= have_q | gain;
  end

  for (genvar k = 0; k < LW_BYTES; k++) begin : g_byte
    localparam int POS = 8 * (LW_BYTES - 1 - k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                entry_q[POS +: 8] <= '0;
      else if (load && gain[k])  entry_q[POS +: 8] <= din[POS +: 8];
    end
  end

  // R8: within one fill, bytes once held are never dropped
  a_r8_have_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((have_q & $past(have_q)) == $past(have_q)));
endmodule

// File: rtl/lw_fill_seq.sv
module lw_fill_seq
  import lwf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_ack,
  input  logic              bus_berr,
  input  logic              bus_ci,
  input  logic [31:0]       bus_data,
  output logic              op_valid,
  output logic [7:0]        op_data,
  output logic              op_err,
  output logic              cw_en,
  output logic              cw_valid,
  output logic [ADDR_W-3:0] cw_line,
  output logic [31:0]       cw_data
);
  localparam int LINE_W = ADDR_W - OFF_W;

  st_e                 st_q;
  logic [LINE_W-1:0]   base_q;
  logic [OFF_W-1:0]    off_q;
  logic                first_q;
  ack_e                width_q;
  ack_e                ack;
  logic                in_fill, accept, resp, mismatch, fault, load, finish;
  logic [LW_BYTES-1:0] have_q, gain, have_nxt;
  logic [OFF_W-1:0]    next_off;
  logic                full;
  logic [31:0]         steered, entry_q;
  logic                op_valid_q, op_err_q, cw_en_q, cw_valid_q;
  logic [7:0]          op_data_q;

  assign ack      = ack_e'(bus_ack);
  assign in_fill  = (st_q == ST_BUS);
  assign accept   = req_valid && !in_fill;
  assign resp     = in_fill && ((ack != ACK_WAIT) || bus_berr);
  assign mismatch = !first_q && (ack != width_q);
  assign fault    = bus_berr || bus_ci || mismatch;
  assign load     = resp && !fault;
  assign finish   = resp && (fault || full);

  lwf_lane_steer u_steer (
    .width    (ack),
    .bus_data (bus_data),
    .steered  (steered)
  );

  lwf_offset_plan u_plan (
    .width    (ack),
    .off      (off_q),
    .have     (have_q),
    .gain     (gain),
    .have_nxt (have_nxt),
    .next_off (next_off),
    .full     (full)
  );

  lwf_entry_asm u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .load    (load),
    .gain    (gain),
    .din     (steered),
    .entry_q (entry_q),
    .have_q  (have_q)
  );

  // Sequencing state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      off_q   <= '0;
      first_q <= 1'b0;
      width_q <= ACK_WAIT;
    end else if (accept) begin
      st_q    <= ST_BUS;
      base_q  <= req_addr[ADDR_W-1:OFF_W];
      off_q   <= req_addr[OFF_W-1:0];
      first_q <= 1'b1;
    end else if (resp) begin
      if (finish) st_q  <= ST_IDLE;
      else        off_q <= next_off;
      if (first_q) width_q <= ack;
      first_q <= 1'b0;
    end
  end

  // Result strobes, one cycle after the ending edge of a bus cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid_q <= 1'b0;
      op_err_q   <= 1'b0;
      op_data_q  <= '0;
      cw_en_q    <= 1'b0;
      cw_valid_q <= 1'b0;
    end else begin
      op_valid_q <= resp && first_q && !bus_berr;
      op_err_q   <= resp && first_q && bus_berr;
      if (resp && first_q) op_data_q <= steered[{~off_q, 3'b000} +: 8];
      cw_en_q    <= finish;
      cw_valid_q <= finish && !fault;
    end
  end

  assign busy      = in_fill;
  assign req_ready = !in_fill;
  assign bus_req   = in_fill;
  assign bus_addr  = {base_q, off_q};
  assign op_valid  = op_valid_q;
  assign op_err    = op_err_q;
  assign op_data   = op_data_q;
  assign cw_en     = cw_en_q;
  assign cw_valid  = cw_valid_q;
  assign cw_line   = base_q;
  assign cw_data   = entry_q;

  // R1: an accepted request opens a bus cycle at its own byte address
  a_r1_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_req && bus_addr == $past(req_addr)));

  // R2: a waiting cycle keeps its address and stays open
  a_r2_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack == 2'b00 && !bus_berr) |=> (bus_req && $stable(bus_addr)));

  // R3: every cycle of one fill stays inside the same long word
  a_r3_same_line: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> (bus_addr[ADDR_W-1:OFF_W] == $past(bus_addr[ADDR_W-1:OFF_W])));

  // R7: operand and operand-error never reported together
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !op_err);

  // R9: no bus cycle follows a bus error
  a_r9_stop_on_berr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_berr) |=> !bus_req);

  // R10: a width change ends the fill with an invalid write
  a_r10_width_change: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && !first_q && ack != ACK_WAIT && ack != width_q) |=> (cw_en && !cw_valid && !bus_req));

  // R11: the entry write happens after the fill has released the bus
  a_r11_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cw_en |-> !bus_req);
endmodule

// File: tb/lw_fill_seq_bench.sv
`timescale 1ns/1ps
module lw_fill_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        busy, bus_req;
  logic [31:0] bus_addr;
  logic [1:0]  bus_ack = 2'b00;
  logic        bus_berr = 1'b0;
  logic        bus_ci = 1'b0;
  logic [31:0] bus_data = '0;
  logic        op_valid, op_err, cw_en, cw_valid;
  logic [7:0]  op_data;
  logic [29:0] cw_line;
  logic [31:0] cw_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lw_fill_seq #(.ADDR_W(32)) u_lw_fill_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .busy(busy), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_berr(bus_berr), .bus_ci(bus_ci), .bus_data(bus_data),
    .op_valid(op_valid), .op_data(op_data), .op_err(op_err), .cw_en(cw_en),
    .cw_valid(cw_valid), .cw_line(cw_line), .cw_data(cw_data)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] ad);
    logic [7:0] t;
    t = 8'(ad[7:0] * 8'd29) + ad[15:8];
    return t ^ 8'hC3;
  endfunction

  function automatic logic [31:0] mem_lw(input logic [31:0] ad);
    logic [31:0] b;
    b = {ad[31:2], 2'b00};
    return {mem_byte(b), mem_byte(b + 1), mem_byte(b + 2), mem_byte(b + 3)};
  endfunction

  // Data a port of width code w returns for a cycle at address ad (R6 lanes).
  function automatic logic [31:0] bus_word(input logic [31:0] ad, input int w, input logic [31:0] junk);
    logic [31:0] wd;
    wd = {ad[31:1], 1'b0};
    if (w == 3)      return mem_lw(ad);
    else if (w == 2) return {mem_byte(wd), mem_byte(wd + 1), junk[15:0]};
    else             return {mem_byte(ad), junk[23:0]};
  endfunction

  function automatic logic [3:0] lanes(input int w, input logic [1:0] off);
    if (w == 3)      return 4'hF;
    else if (w == 2) return off[1] ? 4'b1100 : 4'b0011;
    else             return 4'b0001 << off;
  endfunction

  function automatic logic [1:0] lowest_missing(input logic [3:0] have);
    for (int k = 0; k < 4; k++) if (!have[k]) return 2'(k);
    return 2'd0;
  endfunction

  // fk: 0 none, 1 bus error, 2 cache inhibit, 3 width change; fc: cycle index.
  task automatic do_fill(input logic [31:0] a, input int w, input int maxw,
                         input int fk, input int fc, input bit poke);
    logic [31:0] base;
    logic [3:0]  have;
    logic [1:0]  off;
    int cyc, nw, aw, ncyc;
    bit done, be, ci, flt;
    string tag;
    base = {a[31:2], 2'b00};
    have = '0;
    off  = a[1:0];
    cyc  = 0;
    done = 0;
    ncyc = (w == 3) ? 1 : (w == 2) ? 2 : 4;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    if (poke) begin
      req_addr = a ^ 32'h100;
      chk(req_ready == 1'b0, "R1", "ready during fill", 32'(req_ready), 32'd0);
    end else req_valid = 1'b0;
    while (!done) begin
      tag = (cyc == 0) ? "R1" : (w == 1) ? "R3" : "R4";
      chk(bus_req && bus_addr == (base | 32'(off)), tag, "bus address", bus_addr, base | 32'(off));
      nw = int'($urandom % (maxw + 1));
      for (int i = 0; i < nw; i++) begin
        bus_ack = 2'b00; bus_berr = 1'b0; bus_ci = 1'b0; bus_data = $urandom;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_req && bus_addr == (base | 32'(off)), "R2", "address held in wait", bus_addr, base | 32'(off));
        chk(!op_valid && !cw_en && !op_err, "R2", "silent in wait", {op_valid, cw_en, op_err}, 32'd0);
      end
      aw = (fk == 3 && cyc == fc) ? ((w == 1) ? 2 : 1) : w;
      be = (fk == 1 && cyc == fc);
      ci = (fk == 2 && cyc == fc);
      flt = be || ci || (fk == 3 && cyc == fc);
      bus_ack  = be ? 2'b00 : 2'(aw);
      bus_berr = be;
      bus_ci   = ci;
      bus_data = bus_word(base | 32'(off), aw, $urandom);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; bus_ack = 2'b00; bus_berr = 1'b0; bus_ci = 1'b0;
      if (cyc == 0) begin
        chk(op_valid == !be, "R7", "operand strobe", 32'(op_valid), 32'(!be));
        chk(op_err == be, "R9", "operand error strobe", 32'(op_err), 32'(be));
        if (!be) chk(op_data == mem_byte(a), "R6", "operand byte", 32'(op_data), 32'(mem_byte(a)));
      end else begin
        chk(!op_valid && !op_err, "R7", "no repeat operand", {op_valid, op_err}, 32'd0);
      end
      if (flt) begin
        chk(cw_en && !cw_valid, (fk == 3) ? "R10" : "R9", "invalid write on abort", {cw_en, cw_valid}, 32'b10);
        chk(!busy && !bus_req, (fk == 3) ? "R10" : "R9", "bus released on abort", {busy, bus_req}, 32'd0);
        done = 1;
      end else begin
        have = have | lanes(w, off);
        if (have == 4'hF) begin
          chk(cw_en && cw_valid, "R8", "valid write", {cw_en, cw_valid}, 32'b11);
          chk(cw_data == mem_lw(a), "R6", "entry data", cw_data, mem_lw(a));
          chk(cw_line == a[31:2], "R8", "entry line", 32'(cw_line), 32'(a[31:2]));
          chk(cyc + 1 == ncyc, (w == 3) ? "R5" : (w == 2) ? "R4" : "R3", "cycle count", cyc + 1, ncyc);
          chk(!busy, "R11", "busy low at write", 32'(busy), 32'd0);
          done = 1;
        end else begin
          chk(!cw_en && busy, "R11", "busy mid fill", {cw_en, busy}, 32'b01);
          off = lowest_missing(have);
          cyc++;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(!bus_req && !cw_en && !op_valid, poke ? "R1" : "R11", "idle after fill",
        {bus_req, cw_en, op_valid}, 32'd0);
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w, fk, fc, nc;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && req_ready && !bus_req && !cw_en && !op_valid && !op_err, "R11", "reset state",
        {busy, req_ready, bus_req, cw_en, op_valid, op_err}, 32'b010000);
    rst_n = 1'b1;

    // Directed corner cases.
    do_fill(32'h0000_1003, 1, 0, 0, 0, 0);  // R3: 3,0,1,2
    do_fill(32'h0000_2001, 1, 2, 0, 0, 0);  // R3: 1,0,2,3 with waits
    do_fill(32'h0000_3003, 2, 0, 0, 0, 0);  // R4: word at 2 then 0
    do_fill(32'h0000_4000, 2, 1, 0, 0, 0);  // R4: word at 0 then 2
    do_fill(32'h0000_5002, 3, 3, 0, 0, 0);  // R5: single cycle
    do_fill(32'h0000_6002, 1, 0, 1, 0, 0);  // R9: bus error first cycle
    do_fill(32'h0000_7001, 2, 0, 2, 0, 0);  // R9: inhibit first cycle, operand still out
    do_fill(32'h0000_8003, 1, 0, 3, 2, 0);  // R10: width change on third cycle
    do_fill(32'h0000_9000, 1, 1, 1, 1, 0);  // R9: bus error later
    do_fill(32'h0000_A002, 1, 0, 0, 0, 1);  // R1: request offered while busy
    do_fill(32'h0000_B001, 3, 0, 0, 0, 1);  // R1: offered during a one-cycle fill

    // Constrained random fills.
    for (int n = 0; n < 80; n++) begin
      w  = 1 + int'($urandom % 3);
      nc = (w == 3) ? 1 : (w == 2) ? 2 : 4;
      fk = 0;
      fc = 0;
      if ($urandom % 6 == 0) begin
        fk = 1 + int'($urandom % 3);
        if (fk == 3) begin
          if (nc == 1) fk = 0;
          else fc = 1 + int'($urandom % (nc - 1));
        end else fc = int'($urandom % nc);
      end
      do_fill($urandom, w, int'($urandom % 3), fk, fc, ($urandom % 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule